// File: doc/BRIEF.md
# Serial Scan Register Access Port

This block is a debug-port data register. It lets a serial scan path reach a 128-entry internal register space. One 40-bit frame carries a 32-bit data word, a 7-bit register address and a write flag. The frame is shifted in through `scanIn` while the previous contents leave through `scanOut`. When the update strobe arrives, the block decodes the frame. It then issues exactly one single-cycle write or read on a parallel register bus.

A read is never returned in the same scan that requests it. The bus data is latched when the read pulse completes. It is loaded into the data field on the next capture, so it leaves the chip during the following scan. A debugger drains the last pending result by ending with a read of address 0. That address holds a side-effect-free identification word. Because the bus is touched only on update, a register that advances on every read (a buffer data port, for example) is read exactly once per request.

The port responds only while the instruction register holds the access code (0xC by default). Under any other code, including the chain-select code 0x2, all scan strobes are ignored.

Top module: `scan_reg_port`

## Requirements
- R1: Frame layout, with bit 0 shifted first: bits 0..31 are the data field, bits 32..38 the register address, bit 39 the write flag. On each shift cycle `scanOut` presents the current bit 0, and `scanIn` enters at bit 39.
- R2: An update with write flag 1 produces one cycle of `regWe` in the clock cycle after the update strobe. During that cycle `regAddr` and `regWdata` equal the frame's address and data fields.
- R3: An update with write flag 0 produces one cycle of `regRe` in the clock cycle after the update strobe, with `regAddr` equal to the address field. `regRdata` is latched at the end of that cycle.
- R4: Capture loads the latched read result into bits 0..31 and zeros into bits 32..39. A read's data therefore leaves on the scan after the one that requested it.
- R5: The bus is never strobed by capture or shift. An auto-advancing register receives exactly one read per requested read, and the read of address 0 collects the final pending result.
- R6: Capture, shift and update act only while `irValue` equals the access code 0xC. Under another code (for example 0x2), no bus strobe occurs, the shift register holds, and register contents are unchanged.
- R7: After reset the shift register and the read result are zero, and `regWe` and `regRe` are low.
- R8: `regWe` and `regRe` are never high together, and `regAddr` changes only when an access is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan/bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| irValue | input | 4 | Current instruction register value |
| captureDr | input | 1 | Capture strobe for the data register |
| shiftDr | input | 1 | Shift-enable strobe |
| updateDr | input | 1 | Update strobe |
| scanIn | input | 1 | Serial data in |
| scanOut | output | 1 | Serial data out (bit 0 of frame) |
| regAddr | output | 7 | Register bus address |
| regWdata | output | 32 | Register bus write data |
| regWe | output | 1 | Single-cycle write enable |
| regRe | output | 1 | Single-cycle read strobe |
| regRdata | input | 32 | Register bus read data, valid in the `regRe` cycle |

## Verification
The bench attaches a register model whose address 4 advances a pointer on every read. If the port re-read on capture, or strobed during shift, the entries it collects would skip ahead and the pointer count would be wrong. Reads are followed by a dummy read of address 0. A design that returned data in the same scan, or that left stale address or flag bits on capture, shows up as wrong words in the scanned-out frames. Complete frames are also scanned with instruction 0x2. A port that ignored the instruction would overwrite the register or move `scanOut`.

// File: rtl/scan_port_pkg.sv
package scan_port_pkg;

  typedef struct packed {
    logic load;   // capture result into frame
    logic shift;  // move frame one bit toward scanOut
    logic issue;  // decode frame and start bus access
  } scanStrb_t;

endpackage

// File: rtl/scan_port_ctrl.sv
module scan_port_ctrl
  import scan_port_pkg::*;
#(
  parameter int IR_W        = 4,
  parameter logic [IR_W-1:0] ACCESS_CODE = 4'hC
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [IR_W-1:0] irValue,
  input  logic            captureDr,
  input  logic            shiftDr,
  input  logic            updateDr,
  output scanStrb_t       strb
);

  logic selected;

  always_comb begin
    selected   = (irValue == ACCESS_CODE);
    strb.load  = selected && captureDr;
    strb.shift = selected && shiftDr && !captureDr;
    strb.issue = selected && updateDr && !captureDr && !shiftDr;
  end

  AST_STRB_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.load, strb.shift, strb.issue})); // R5

  AST_IDLE_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rstN)
    (irValue != ACCESS_CODE) |-> !(strb.load || strb.shift || strb.issue)); // R6

endmodule

// File: rtl/scan_port_datapath.sv
module scan_port_datapath
  import scan_port_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  scanStrb_t         strb,
  input  logic              scanIn,
  output logic              scanOut,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  output logic              regWe,
  output logic              regRe,
  input  logic [DATA_W-1:0] regRdata
);

  localparam int FRAME_W = DATA_W + ADDR_W + 1;
  localparam int FLAG_B  = FRAME_W - 1;

  logic [FRAME_W-1:0] frameReg;
  logic [DATA_W-1:0]  readResult;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameReg   <= '0;
      readResult <= '0;
      regAddr    <= '0;
      regWdata   <= '0;
      regWe      <= 1'b0;
      regRe      <= 1'b0;
    end else begin
      regWe <= 1'b0;
      regRe <= 1'b0;
      if (strb.load)
        frameReg <= {{(ADDR_W + 1){1'b0}}, readResult};
      else if (strb.shift)
        frameReg <= {scanIn, frameReg[FRAME_W-1:1]};
      if (strb.issue) begin
        regAddr  <= frameReg[DATA_W +: ADDR_W];
        regWdata <= frameReg[DATA_W-1:0];
        regWe    <= frameReg[FLAG_B];
        regRe    <= !frameReg[FLAG_B];
      end
      if (regRe)
        readResult <= regRdata;
    end
  end

  assign scanOut = frameReg[0];

  AST_BUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(regWe && regRe)); // R8

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.issue |=> $stable(regAddr)); // R8

  AST_CAPTURE_CLEARS_HEADER: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (frameReg[FRAME_W-1:DATA_W] == '0)); // R4

  AST_FRAME_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.load || strb.shift) |=> $stable(frameReg)); // R6

  AST_RESULT_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    !regRe |=> $stable(readResult)); // R3

endmodule

// File: rtl/scan_reg_port.sv
module scan_reg_port
  import scan_port_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 7,
  parameter int IR_W   = 4,
  parameter logic [IR_W-1:0] ACCESS_CODE = 4'hC
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IR_W-1:0]   irValue,
  input  logic              captureDr,
  input  logic              shiftDr,
  input  logic              updateDr,
  input  logic              scanIn,
  output logic              scanOut,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  output logic              regWe,
  output logic              regRe,
  input  logic [DATA_W-1:0] regRdata
);

  scanStrb_t strb;

  scan_port_ctrl #(
    .IR_W        (IR_W),
    .ACCESS_CODE (ACCESS_CODE)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .irValue   (irValue),
    .captureDr (captureDr),
    .shiftDr   (shiftDr),
    .updateDr  (updateDr),
    .strb      (strb)
  );

  scan_port_datapath #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .scanIn   (scanIn),
    .scanOut  (scanOut),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regWe    (regWe),
    .regRe    (regRe),
    .regRdata (regRdata)
  );

  AST_STROBE_FROM_UPDATE: assert property (@(posedge clk) disable iff (!rstN)
    (regWe || regRe) |-> $past(updateDr && (irValue == ACCESS_CODE))); // R2

  AST_NO_BUS_IN_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    $past(!updateDr) |-> !(regWe || regRe)); // R5

endmodule

// File: tb/tb_scan_reg_port.sv
module tb_scan_reg_port;

  localparam logic [31:0] ID_WORD = 32'h1D5C_A9E1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  irValue = 4'hC;
  logic        captureDr = 1'b0, shiftDr = 1'b0, updateDr = 1'b0, scanIn = 1'b0;
  logic        scanOut;
  logic [6:0]  regAddr;
  logic [31:0] regWdata, regRdata;
  logic        regWe, regRe;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  scan_reg_port dut (
    .clk(clk), .rstN(rstN), .irValue(irValue), .captureDr(captureDr),
    .shiftDr(shiftDr), .updateDr(updateDr), .scanIn(scanIn), .scanOut(scanOut),
    .regAddr(regAddr), .regWdata(regWdata), .regWe(regWe), .regRe(regRe),
    .regRdata(regRdata)
  );

  function automatic logic [31:0] fifoWord(input int idx);
    return 32'hC0DE_0000 + 32'(idx) * 32'h0001_0011;
  endfunction

  // register space attached to the bus
  logic [31:0] busMem [128];
  int busPtr = 0;
  initial for (int i = 0; i < 128; i++) busMem[i] = 32'h0;

  assign regRdata = (regAddr == 7'd0) ? ID_WORD :
                    (regAddr == 7'd4) ? fifoWord(busPtr) : busMem[regAddr];

  always @(posedge clk) begin
    if (regWe && regAddr != 7'd0 && regAddr != 7'd4) busMem[regAddr] <= regWdata;
    if (regRe && regAddr == 7'd4) busPtr <= busPtr + 1;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference model, advanced on every rising edge
  bit          mq[$];
  logic [31:0] mResult, mWdata;
  logic [6:0]  mAddr;
  logic        mWe, mRe;
  logic [31:0] mMem [128];
  int          mPtr;

  always @(posedge clk) begin
    logic [31:0] nextRes;
    logic        act;
    if (!rstN) begin
      mq.delete();
      for (int i = 0; i < 40; i++) mq.push_back(1'b0);
      mResult = 0; mWdata = 0; mAddr = 0; mWe = 0; mRe = 0; mPtr = 0;
      for (int i = 0; i < 128; i++) mMem[i] = 0;
    end else begin
      act = (irValue == 4'hC);
      if (mWe && mAddr != 0 && mAddr != 4) mMem[mAddr] = mWdata;
      nextRes = mResult;
      if (mRe) begin
        if (mAddr == 0) nextRes = ID_WORD;
        else if (mAddr == 4) begin nextRes = fifoWord(mPtr); mPtr++; end
        else nextRes = mMem[mAddr];
      end
      if (act && captureDr) begin
        mq.delete();
        for (int i = 0; i < 32; i++) mq.push_back(mResult[i]);
        for (int i = 0; i < 8; i++) mq.push_back(1'b0);
        mWe = 0; mRe = 0;
      end else if (act && shiftDr) begin
        void'(mq.pop_front());
        mq.push_back(scanIn);
        mWe = 0; mRe = 0;
      end else if (act && updateDr) begin
        for (int i = 0; i < 32; i++) mWdata[i] = mq[i];
        for (int i = 0; i < 7; i++) mAddr[i] = mq[32 + i];
        mWe = mq[39];
        mRe = !mq[39];
      end else begin
        mWe = 0; mRe = 0;
      end
      mResult = nextRes;
    end
  end

  // cycle-by-cycle comparison (R1 serial order, R2/R3 strobes)
  always @(negedge clk) begin
    if (rstN) begin
      chk("R1 scanOut", 64'(scanOut), 64'(mq[0]));
      chk("R2 regWe", 64'(regWe), 64'(mWe));
      chk("R3 regRe", 64'(regRe), 64'(mRe));
      if (regWe || regRe) chk("R8 regAddr", 64'(regAddr), 64'(mAddr));
      if (regWe) chk("R2 regWdata", 64'(regWdata), 64'(mWdata));
    end
  end

  task automatic scanFrame(input logic [31:0] d, input logic [6:0] a, input logic w,
                           output logic [39:0] got);
    logic [39:0] f;
    f = {w, a, d};
    @(negedge clk); captureDr = 1'b1;
    @(negedge clk); captureDr = 1'b0; shiftDr = 1'b1;
    for (int i = 0; i < 40; i++) begin
      got[i] = scanOut;
      scanIn = f[i];
      @(negedge clk);
    end
    shiftDr = 1'b0; updateDr = 1'b1;
    @(negedge clk); updateDr = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [39:0] got;
    repeat (3) @(negedge clk);
    // R7: reset state
    chk("R7 scanOut reset", 64'(scanOut), 64'h0);
    chk("R7 regWe reset", 64'(regWe), 64'h0);
    chk("R7 regRe reset", 64'(regRe), 64'h0);
    rstN = 1'b1;

    // R2: write, first capture returns zero result (R7)
    scanFrame(32'hA5A5_1234, 7'd9, 1'b1, got);
    chk("R7 first capture zero", 64'(got), 64'h0);
    chk("R2 write landed", 64'(busMem[9]), 64'hA5A5_1234);

    // R3/R4: read addr 9, result arrives on next scan
    scanFrame(32'hFFFF_FFFF, 7'd9, 1'b0, got);
    chk("R4 no same-scan data", 64'(got[31:0]), 64'h0);
    scanFrame(32'h0, 7'd0, 1'b0, got);
    chk("R4 delayed read data", 64'(got[31:0]), 64'hA5A5_1234);
    chk("R4 header zeros", 64'(got[39:32]), 64'h0);
    scanFrame(32'h0, 7'd0, 1'b0, got);
    chk("R5 id via dummy read", 64'(got[31:0]), 64'(ID_WORD));

    // R5: auto-advancing register read exactly once per request
    scanFrame(32'h0, 7'd4, 1'b0, got);
    scanFrame(32'h0, 7'd4, 1'b0, got);
    chk("R5 fifo entry 0", 64'(got[31:0]), 64'(fifoWord(0)));
    scanFrame(32'h0, 7'd4, 1'b0, got);
    chk("R5 fifo entry 1", 64'(got[31:0]), 64'(fifoWord(1)));
    scanFrame(32'h0, 7'd0, 1'b0, got);
    chk("R5 fifo entry 2", 64'(got[31:0]), 64'(fifoWord(2)));
    chk("R5 pointer count", 64'(busPtr), 64'd3);

    // R6: other instruction codes ignore strobes
    irValue = 4'h2;
    scanFrame(32'h5555_0000, 7'd9, 1'b1, got);
    chk("R6 scanOut held", 64'(got), {24'h0, {40{got[0]}}});
    chk("R6 no write", 64'(busMem[9]), 64'hA5A5_1234);
    scanFrame(32'h0, 7'd4, 1'b0, got);
    chk("R6 no read", 64'(busPtr), 64'd3);
    irValue = 4'hC;

    // R2/R3: write then read back a second location
    scanFrame(32'h0BAD_F00D, 7'd127, 1'b1, got);
    scanFrame(32'h0, 7'd127, 1'b0, got);
    scanFrame(32'h0, 7'd0, 1'b0, got);
    chk("R3 readback top addr", 64'(got[31:0]), 64'h0BAD_F00D);

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule